// File: doc/BRIEF.md
# Sync Reference Timing Measurement Unit

This block takes three reference sync inputs: line (H), field (V) and a slow frame-group marker (F). They arrive already aligned to the sample clock. Each input is cleaned by a two-flop synchroniser and a two-cycle persistence filter. The block then works out, per input, which phase is the active pulse: the shorter of the high and low phases. From that point every measurement runs from the leading edge of the active pulse, whatever its polarity.

Five measurements run at once. The first three count sample-clock cycles and lines:
- the line period in clock cycles;
- the clock-cycle length of sixteen consecutive lines;
- the line count of one field.

The other two count lines over longer spans:
- the line count across two fields;
- the line count across one F period.

The multi-period windows give the resolution needed to separate nearly equal frame rates. Each result is held in a read-only register and loaded in one step when its window closes. A status word reports the detected polarities and which measurements are currently valid. A host reads any register by placing an address and sampling the data one cycle later.

Top module: `srt_top`

## Requirements
- R1: After a synchronous reset, every measurement register reads 0 and the status word at address 0x9 reads 0x04.
- R2: Address 0xA returns the number of clock cycles between two successive H leading edges.
- R3: Address 0xB returns the number of clock cycles spanned by sixteen consecutive H periods.
- R4: Address 0xC returns the number of H leading edges counted after one V leading edge, up to and including the next V leading edge.
- R5: Address 0xD returns the H leading edges counted across two consecutive V periods, using the same counting rule as R4.
- R6: Address 0xE returns the H leading edges counted across one F period, using the same counting rule as R4.
- R7: The active pulse of each input is its shorter phase. Status bits 3, 4 and 6 give the H, V and F polarity (1 = active high). All measurements come out the same for either polarity.
- R8: In the status word, bit 0 is H period valid, bit 1 is V count valid, bit 5 is F count valid, bit 2 always reads 1 (digital timing input), and the other bits read 0. A valid bit sets once its first window completes.
- R9: A level change on a sync input that lasts less than two clock cycles has no effect on any measurement.
- R10: A count that reaches the all-ones value of its register width stays there and does not wrap.
- R11: If a measurement sees no marker edge for TIMEOUT_CYC cycles, its register clears to 0 and its valid bit drops. Measuring resumes when edges return.
- R12: A measurement register changes only when its window closes or on a timeout. Read data is registered with one cycle of latency, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| h_ref | input | 1 | Line reference sync |
| v_ref | input | 1 | Field reference sync |
| f_ref | input | 1 | Frame-group reference sync |
| rd_addr | input | AW | Register read address |
| rd_data | output | DW | Registered read data |

## Verification
Several input patterns are applied, and each one separates a different kind of fault.
- A baseline pattern has active-low pulses, 20-cycle lines and 10-line fields. It fixes the expected value of every register.
- An inverted, longer pattern makes the polarity decision flip. A design that still keys on the wrong edge, or that remembers the old period, gives wrong counts here.
- Single-cycle spikes are injected in the middle of each line. They separate a working persistence filter from one that passes glitches into the period count.
- An 80-cycle line applied with narrow register widths pushes the counters into saturation.
- Removing every input and then restoring it exercises the timeout clear and the restart.

// File: rtl/srt_pkg.sv
package srt_pkg;
  // register addresses
  localparam int unsigned ADR_STATUS = 9;
  localparam int unsigned ADR_HPER   = 10;
  localparam int unsigned ADR_H16    = 11;
  localparam int unsigned ADR_VLIN   = 12;
  localparam int unsigned ADR_V2LIN  = 13;
  localparam int unsigned ADR_FLIN   = 14;

  // status bit positions
  localparam int unsigned ST_HVAL  = 0;
  localparam int unsigned ST_VVAL  = 1;
  localparam int unsigned ST_DIG   = 2;
  localparam int unsigned ST_HPOL  = 3;
  localparam int unsigned ST_VPOL  = 4;
  localparam int unsigned ST_FVAL  = 5;
  localparam int unsigned ST_FPOL  = 6;

  // sync channel index
  typedef enum logic [1:0] {CH_H = 2'd0, CH_V = 2'd1, CH_F = 2'd2} sync_ch_e;
  localparam int unsigned NUM_CH = 3;
endpackage

// File: rtl/srt_deglitch.sv
// Two-flop synchroniser followed by a filter that accepts a new level
// only after it has been seen on two consecutive samples.
module srt_deglitch (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic s1, s2, s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      s2_q <= 1'b0;
      dout <= 1'b0;
    end else begin
      s1   <= din;
      s2   <= s1;
      s2_q <= s2;
      if (s2 == s2_q && s2 != dout)
        dout <= s2;
    end
  end
endmodule

// File: rtl/srt_polarity.sv
// Tracks the length of the high and low phases, takes the shorter one as
// the active pulse and emits a one-cycle strobe on its leading edge.
module srt_polarity #(
  parameter int RUNW = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic lead,
  output logic pol,
  output logic known
);
  logic            lvl_q;
  logic [RUNW-1:0] run, hi_len, lo_len;
  logic            hi_seen, lo_seen;
  logic            rise, fall;
  logic            pol_nx, known_nx, lead_nx;

  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;

  always_comb begin
    pol_nx   = pol;
    known_nx = known;
    if (rise) begin
      pol_nx   = (hi_len < run);
      known_nx = known | hi_seen;
    end else if (fall) begin
      pol_nx   = (run < lo_len);
      known_nx = known | lo_seen;
    end
    lead_nx = known_nx & ((rise & pol_nx) | (fall & ~pol_nx));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q   <= 1'b0;
      run     <= '0;
      hi_len  <= '0;
      lo_len  <= '0;
      hi_seen <= 1'b0;
      lo_seen <= 1'b0;
      pol     <= 1'b0;
      known   <= 1'b0;
      lead    <= 1'b0;
    end else begin
      lvl_q <= lvl;
      if (rise | fall)
        run <= RUNW'(1);
      else if (run != '1)
        run <= run + 1'b1;
      if (rise) begin
        lo_len  <= run;
        lo_seen <= 1'b1;
      end
      if (fall) begin
        hi_len  <= run;
        hi_seen <= 1'b1;
      end
      pol   <= pol_nx;
      known <= known_nx;
      lead  <= lead_nx;
    end
  end
endmodule

// File: rtl/srt_window_count.sv
// Counts tick events across NPER marker periods, saturating, and loads
// the result register in one step at the closing marker.
module srt_window_count #(
  parameter int CW      = 16,
  parameter int NPER    = 1,
  parameter int TIMEOUT = 1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          marker,
  input  logic          tick,
  output logic [CW-1:0] result,
  output logic          valid
);
  localparam int PW  = (NPER > 1) ? $clog2(NPER) : 1;
  localparam int TOW = $clog2(TIMEOUT + 1);

  logic [CW-1:0]  cnt, cnt_inc;
  logic [PW-1:0]  per;
  logic [TOW-1:0] idle;
  logic           started, last, expired;

  assign cnt_inc = (tick && cnt != '1) ? cnt + 1'b1 : cnt;
  assign last    = (per == PW'(NPER - 1));
  assign expired = (idle == TOW'(TIMEOUT));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      per     <= '0;
      idle    <= '0;
      started <= 1'b0;
      result  <= '0;
      valid   <= 1'b0;
    end else if (marker) begin
      idle <= '0;
      if (!started) begin
        started <= 1'b1;
        cnt     <= '0;
        per     <= '0;
      end else if (last) begin
        result <= cnt_inc;
        valid  <= 1'b1;
        cnt    <= '0;
        per    <= '0;
      end else begin
        cnt <= cnt_inc;
        per <= per + 1'b1;
      end
    end else if (expired) begin
      started <= 1'b0;
      valid   <= 1'b0;
      result  <= '0;
      cnt     <= '0;
      per     <= '0;
    end else begin
      idle <= idle + 1'b1;
      cnt  <= cnt_inc;
    end
  end
endmodule

// File: rtl/srt_top.sv
module srt_top #(
  parameter int HW          = 16,
  parameter int VW          = 12,
  parameter int RUNW        = 20,
  parameter int TIMEOUT_CYC = 6000000,
  parameter int AW          = 4,
  parameter int DW          = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          h_ref,
  input  logic          v_ref,
  input  logic          f_ref,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  import srt_pkg::*;

  localparam int H16W = HW + 4;
  localparam int V2W  = VW + 1;
  localparam int FW   = VW + 4;

  logic [NUM_CH-1:0] raw, clean, lead, pol, known;
  assign raw = {f_ref, v_ref, h_ref};

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
    srt_deglitch u_flt (
      .clk (clk),
      .rst (rst),
      .din (raw[gi]),
      .dout(clean[gi])
    );
    srt_polarity #(.RUNW(RUNW)) u_pol (
      .clk  (clk),
      .rst  (rst),
      .lvl  (clean[gi]),
      .lead (lead[gi]),
      .pol  (pol[gi]),
      .known(known[gi])
    );
  end

  logic h_lead, v_lead, f_lead;
  assign h_lead = lead[CH_H];
  assign v_lead = lead[CH_V];
  assign f_lead = lead[CH_F];

  logic [HW-1:0]   m_hper;
  logic [H16W-1:0] m_h16;
  logic [VW-1:0]   m_vlin;
  logic [V2W-1:0]  m_v2lin;
  logic [FW-1:0]   m_flin;
  logic            ok_hper, ok_h16, ok_vlin, ok_v2lin, ok_flin;

  srt_window_count #(.CW(HW), .NPER(1), .TIMEOUT(TIMEOUT_CYC)) u_hper (
    .clk(clk), .rst(rst), .marker(h_lead), .tick(1'b1),
    .result(m_hper), .valid(ok_hper)
  );
  srt_window_count #(.CW(H16W), .NPER(16), .TIMEOUT(TIMEOUT_CYC)) u_h16 (
    .clk(clk), .rst(rst), .marker(h_lead), .tick(1'b1),
    .result(m_h16), .valid(ok_h16)
  );
  srt_window_count #(.CW(VW), .NPER(1), .TIMEOUT(TIMEOUT_CYC)) u_vlin (
    .clk(clk), .rst(rst), .marker(v_lead), .tick(h_lead),
    .result(m_vlin), .valid(ok_vlin)
  );
  srt_window_count #(.CW(V2W), .NPER(2), .TIMEOUT(TIMEOUT_CYC)) u_v2lin (
    .clk(clk), .rst(rst), .marker(v_lead), .tick(h_lead),
    .result(m_v2lin), .valid(ok_v2lin)
  );
  srt_window_count #(.CW(FW), .NPER(1), .TIMEOUT(TIMEOUT_CYC)) u_flin (
    .clk(clk), .rst(rst), .marker(f_lead), .tick(h_lead),
    .result(m_flin), .valid(ok_flin)
  );

  logic [DW-1:0] status;
  always_comb begin
    status          = '0;
    status[ST_HVAL] = ok_hper;
    status[ST_VVAL] = ok_vlin;
    status[ST_DIG]  = 1'b1;
    status[ST_HPOL] = pol[CH_H];
    status[ST_VPOL] = pol[CH_V];
    status[ST_FVAL] = ok_flin;
    status[ST_FPOL] = pol[CH_F];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        AW'(ADR_STATUS): rd_data <= status;
        AW'(ADR_HPER):   rd_data <= DW'(m_hper);
        AW'(ADR_H16):    rd_data <= DW'(m_h16);
        AW'(ADR_VLIN):   rd_data <= DW'(m_vlin);
        AW'(ADR_V2LIN):  rd_data <= DW'(m_v2lin);
        AW'(ADR_FLIN):   rd_data <= DW'(m_flin);
        default:         rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/srt_checker.sv
module srt_checker #(
  parameter int HW = 16,
  parameter int AW = 4,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          h_lead,
  input logic          v_lead,
  input logic          h_valid,
  input logic [HW-1:0] h_per,
  input logic [AW-1:0] rd_addr,
  input logic [DW-1:0] rd_data
);
  import srt_pkg::*;

  // R12: H period register moves only after a leading edge or on a timeout clear
  a_r12_atomic_update: assert property (@(posedge clk) disable iff (rst)
    !$stable(h_per) |-> ($past(h_lead) || h_per == '0));

  // R11: an invalid H measurement always reads as zero
  a_r11_invalid_zero: assert property (@(posedge clk) disable iff (rst)
    !h_valid |-> h_per == '0);

  // R7: leading-edge strobes are single-cycle
  a_r7_h_single_lead: assert property (@(posedge clk) disable iff (rst)
    h_lead |=> !h_lead);
  a_r7_v_single_lead: assert property (@(posedge clk) disable iff (rst)
    v_lead |=> !v_lead);

  // R8: the input-type bit of the status word always reads 1
  a_r8_status_type: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_addr) == AW'(ADR_STATUS)) |-> rd_data[ST_DIG]);

  // R2: a read of the H period address returns the held measurement
  a_r2_read_hper: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_addr) == AW'(ADR_HPER)) |-> rd_data == DW'($past(h_per)));
endmodule

bind srt_top srt_checker #(.HW(HW), .AW(AW), .DW(DW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .h_lead (h_lead),
  .v_lead (v_lead),
  .h_valid(ok_hper),
  .h_per  (m_hper),
  .rd_addr(rd_addr),
  .rd_data(rd_data)
);

// File: tb/tb_srt_top.sv
module tb_srt_top;
  localparam int CLK_P   = 10;
  localparam int HW      = 6;
  localparam int VW      = 8;
  localparam int AW      = 4;
  localparam int DW      = 32;
  localparam int TMO     = 1000;

  logic clk = 1'b0;
  logic rst;
  logic h_ref, v_ref, f_ref;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // generator configuration
  bit run_en = 0;
  int hp = 20, hpw = 3, vl = 10, vpw = 2, fm = 2;
  bit hpol = 0, vpol = 0, glitch = 0;

  always #(CLK_P/2) clk = ~clk;

  srt_top #(.HW(HW), .VW(VW), .RUNW(12), .TIMEOUT_CYC(TMO), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .h_ref(h_ref), .v_ref(v_ref), .f_ref(f_ref),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // sync pattern generator
  initial begin
    int col, line;
    bit ha, va, fa;
    col = 0; line = 0;
    h_ref = 1'b1; v_ref = 1'b1; f_ref = 1'b1;
    forever begin
      @(negedge clk);
      if (!run_en) begin
        col = 0; line = 0;
        h_ref = hpol ? 1'b0 : 1'b1;
        v_ref = vpol ? 1'b0 : 1'b1;
        f_ref = vpol ? 1'b0 : 1'b1;
      end else begin
        ha = (col < hpw);
        if (glitch && col == hp/2) ha = ~ha;
        va = ((line % vl) < vpw);
        fa = (line == 0);
        h_ref = hpol ? ha : ~ha;
        v_ref = vpol ? va : ~va;
        f_ref = vpol ? fa : ~fa;
        col++;
        if (col >= hp) begin
          col = 0;
          line++;
          if (line >= vl*fm) line = 0;
        end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk);
    rd_addr = AW'(a);
    @(posedge clk);
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(string tag, int e_h, int e_h16, int e_v, int e_v2, int e_f, int e_st);
    int v;
    rd(10, v); chk({"R2 ", tag}, v, e_h);
    rd(11, v); chk({"R3 ", tag}, v, e_h16);
    rd(12, v); chk({"R4 ", tag}, v, e_v);
    rd(13, v); chk({"R5 ", tag}, v, e_v2);
    rd(14, v); chk({"R6 ", tag}, v, e_f);
    rd(9, v);  chk({"R8/R7 status ", tag}, v, e_st);
  endtask

  task automatic t_reset();
    int v;
    for (int a = 9; a <= 14; a++) begin
      rd(a, v);
      chk("R1 reset value", v, (a == 9) ? 4 : 0);
    end
  endtask

  task automatic t_baseline();
    hp = 20; hpw = 3; vl = 10; vpw = 2; fm = 2; hpol = 0; vpol = 0; glitch = 0;
    run_en = 1;
    wait_cyc(3000);
    check_all("baseline", 20, 320, 10, 20, 20, 'h27);
  endtask

  task automatic t_inverted();
    hp = 24; vl = 12; hpol = 1; vpol = 1;
    wait_cyc(3000);
    // R7: active-high on all three channels sets bits 3, 4 and 6
    check_all("inverted", 24, 384, 12, 24, 24, 'h7F);
  endtask

  task automatic t_glitch();
    hp = 20; vl = 10; hpol = 0; vpol = 0; glitch = 1;
    wait_cyc(3000);
    check_all("R9 glitch", 20, 320, 10, 20, 20, 'h27);
    glitch = 0;
  endtask

  task automatic t_unmapped();
    int v;
    rd(3, v);  chk("R12 unmapped 0x3", v, 0);
    rd(15, v); chk("R12 unmapped 0xF", v, 0);
  endtask

  task automatic t_saturate();
    int v;
    hp = 80;
    wait_cyc(4000);
    rd(10, v); chk("R10 H period saturates", v, 63);
    rd(11, v); chk("R10 16-line count saturates", v, 1023);
  endtask

  task automatic t_timeout();
    int v;
    run_en = 0;
    wait_cyc(1500);
    for (int a = 10; a <= 14; a++) begin
      rd(a, v);
      chk("R11 timeout clears register", v, 0);
    end
    rd(9, v); chk("R11 valid bits cleared", v & 'h23, 0);
  endtask

  task automatic t_recover();
    hp = 20; vl = 10;
    run_en = 1;
    wait_cyc(3000);
    check_all("R11 recovery", 20, 320, 10, 20, 20, 'h27);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    rd_addr = '0;
    rst = 1'b1;
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(2);
    t_reset();
    t_baseline();
    t_inverted();
    t_glitch();
    t_unmapped();
    t_saturate();
    t_timeout();
    t_recover();
    finish_run();
  end

  initial begin
    #(CLK_P * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule